// File: doc/BRIEF.md
# Toggle Handshake Mailbox

This block is a memory-mapped mailbox that lets a host processor and fabric logic pass 32-bit words using a two-phase handshake. The host writes a word into its data register and then inverts its control bit. Either direction of that change counts as one request. The fabric side remembers the last control value it acted on. Whenever the live value differs from it, the fabric takes the host word, posts a reply word and inverts its own control bit.

The reply is the received word rotated left by one bit. The reply word and the fabric control bit are loaded on the same clock edge, so the host never sees the toggle ahead of the data. The host waits for the fabric toggle before it starts the next exchange.

A ten-bit counter tallies completed exchanges. It raises a one-cycle frame pulse when it wraps after 1024 exchanges. Bus and fabric share one clock. The asynchronous reset is released synchronously inside the block.

Top module: `toggle_mailbox`

## Requirements
- R1: After reset, reads at byte offsets 0x0, 0x4, 0x8 and 0xC all return zero, the exchange count is zero and the frame pulse is low. No exchange happens without a host toggle.
- R2: A write to offset 0x0 stores the host data word, and a read at 0x0 returns it.
- R3: The host control bit is bit 0 of the word at offset 0x8. Bits 31..1 of a write there are discarded and read back as zero.
- R4: When the host control bit changes from 0 to 1, the fabric control bit (offset 0xC, bit 0) inverts exactly one clock after the host write edge, and not earlier.
- R5: A change of the host control bit from 1 to 0 is also a request, handled with the same one-clock timing.
- R6: On each request, offset 0x4 shows the host data word rotated left by one bit. It becomes visible on the same edge as the fabric toggle.
- R7: Rewriting the host control bit with its current value, or writing new host data without a toggle, leaves the fabric control bit and the reply word unchanged.
- R8: Writes to offsets 0x4 and 0xC are ignored, and so are writes whose byte address has bits 1..0 not zero.
- R9: The exchange count output increments by one on each fabric toggle and wraps from 1023 to 0.
- R10: The frame pulse is high for exactly one cycle: the cycle in which the count has just wrapped to 0 on the 1024th exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by bus and fabric logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| xfer_cnt | output | 10 | Completed exchange count |
| frame_done | output | 1 | One-cycle pulse on the wrap after 1024 exchanges |

## Verification
The bench reads the fabric control bit in the cycle after the host toggle is written, and again one cycle later. A design that answers combinationally, or one clock late, therefore fails on one side of that window. Toggles run in both directions. A detector that only catches rising edges would miss every second exchange. Idle rewrites of the control bit check for a detector that compares against the wrong stored value, since such a design would fire on the rewrite. Writes to the fabric-owned registers would show up as corrupted reply or control reads. The bench runs a full 1024-exchange frame. An off-by-one wrap, or a frame pulse lasting more than one cycle, is then visible at the frame boundary.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  localparam int ADDR_W = 4;
  localparam int IDX_LSB = 2;

  typedef enum logic [1:0] {
    REG_HDATA = 2'd0,
    REG_REPLY = 2'd1,
    REG_HCTRL = 2'd2,
    REG_FCTRL = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/tmb_rst_sync.sv
module tmb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tmb_regfile.sv
module tmb_regfile
  import tmb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] reply,
  input  logic              fack,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] hdata,
  output logic              hreq
);
  reg_idx_e    idx;
  logic        hit;
  logic        hdata_en, hreq_en;
  logic [DATA_W-1:0] hdata_q;
  logic        hreq_q;

  assign idx      = reg_idx_e'(addr[ADDR_W-1:IDX_LSB]);
  assign hit      = wr && (addr[IDX_LSB-1:0] == '0);
  assign hdata_en = hit && (idx == REG_HDATA);
  assign hreq_en  = hit && (idx == REG_HCTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hdata_q <= '0;
    else if (hdata_en) hdata_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hreq_q <= 1'b0;
    else if (hreq_en) hreq_q <= wdata[0];
  end

  always_comb begin
    unique case (idx)
      REG_HDATA: rdata = hdata_q;
      REG_REPLY: rdata = reply;
      REG_HCTRL: rdata = {{(DATA_W-1){1'b0}}, hreq_q};
      default:   rdata = {{(DATA_W-1){1'b0}}, fack};
    endcase
  end

  assign hdata = hdata_q;
  assign hreq  = hreq_q;

  // R3: only bit 0 of a control write is kept
  p_ctrl_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_en |=> (hreq == $past(wdata[0])));
  // R2: host data is stable when not addressed
  p_hdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hdata_en |=> $stable(hdata));
endmodule

// File: rtl/tmb_responder.sv
module tmb_responder #(
  parameter int DATA_W = 32,
  parameter int ROT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] hdata,
  input  logic              hreq,
  output logic [DATA_W-1:0] reply,
  output logic              fack,
  output logic              req
);
  logic              seen_q, seen_d;
  logic              fack_q, fack_d;
  logic [DATA_W-1:0] reply_q, reply_d, rot_word;

  assign req      = hreq ^ seen_q;
  assign rot_word = (hdata << ROT) | (hdata >> (DATA_W - ROT));

  always_comb begin
    seen_d  = seen_q;
    fack_d  = fack_q;
    reply_d = reply_q;
    if (req) begin
      seen_d  = hreq;
      fack_d  = ~fack_q;
      reply_d = rot_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      fack_q  <= 1'b0;
      reply_q <= '0;
    end else begin
      seen_q  <= seen_d;
      fack_q  <= fack_d;
      reply_q <= reply_d;
    end
  end

  assign reply = reply_q;
  assign fack  = fack_q;

  // R4/R5: a request is answered by a toggle on the next edge
  p_ack_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (fack != $past(fack)));
  // R6: the reply is the rotated host word, loaded with the toggle
  p_reply_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (reply == {$past(hdata[DATA_W-2:0]), $past(hdata[DATA_W-1])}));
  // R7: no request, no change
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(fack) && $stable(reply)));
  // R5: a handled request is cleared on the following cycle
  p_req_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req || $changed(hreq));
endmodule

// File: rtl/tmb_xfer_counter.sv
module tmb_xfer_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             frame_done
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (inc) begin
      cnt_d  = cnt_q + 1'b1;
      done_d = (cnt_q == CNT_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign cnt        = cnt_q;
  assign frame_done = done_q;

  // R9: count steps by one per exchange
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (cnt == $past(cnt) + 1'b1));
  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));
  // R10: frame pulse only at the wrap and only one cycle long
  p_frame_at_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (cnt == '0));
  p_frame_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: rtl/toggle_mailbox.sv
module toggle_mailbox
  import tmb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10,
  parameter int ROT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  xfer_cnt,
  output logic              frame_done
);
  logic              rst_n_s;
  logic [DATA_W-1:0] hdata, reply;
  logic              hreq, fack, req;

  tmb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  tmb_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .reply(reply), .fack(fack), .rdata(bus_rdata),
    .hdata(hdata), .hreq(hreq)
  );

  tmb_responder #(.DATA_W(DATA_W), .ROT(ROT)) u_resp (
    .clk(clk), .rst_n(rst_n_s), .hdata(hdata), .hreq(hreq),
    .reply(reply), .fack(fack), .req(req)
  );

  tmb_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .inc(req),
    .cnt(xfer_cnt), .frame_done(frame_done)
  );

  // R8: fabric-owned registers ignore bus writes
  p_fabric_ro_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && !req) |=> ($stable(reply) && $stable(fack)));
  // R1: no toggle leaves the fabric idle while reset is held
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n_s |-> (!fack && !frame_done && (xfer_cnt == '0)));
endmodule

// File: tb/tb_toggle_mailbox.sv
module tb_toggle_mailbox;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [9:0]  xfer_cnt;
  logic        frame_done;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  logic [31:0] obs_q[$];

  logic       hc_model = 1'b0;
  logic       fc_model = 1'b0;
  int         cnt_model = 0;
  logic [31:0] last_reply = '0;

  always #10 clk = ~clk;

  toggle_mailbox dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_cnt(xfer_cnt), .frame_done(frame_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: one full host exchange
  task automatic exchange(input logic [31:0] d);
    logic [31:0] v;
    wr(4'h0, d);
    wr(4'h8, {31'b0, ~hc_model});
    hc_model = ~hc_model;
    rd(4'hC, v);
    chk(hc_model ? "R4 toggle not early" : "R5 toggle not early", v, {31'b0, fc_model});
    chk("R10 no pulse early", {31'b0, frame_done}, 32'd0);
    @(negedge clk);
    fc_model = ~fc_model;
    cnt_model = (cnt_model + 1) % 1024;
    rd(4'hC, v);
    chk(hc_model ? "R4 toggle after one clock" : "R5 toggle after one clock", v, {31'b0, fc_model});
    chk("R9 count", {22'b0, xfer_cnt}, cnt_model);
    chk("R10 frame pulse", {31'b0, frame_done}, {31'b0, cnt_model == 0});
    exp_q.push_back({d[30:0], d[31]});
    rd(4'h4, v);
    obs_q.push_back(v);
    last_reply = {d[30:0], d[31]};
  endtask

  // monitor: compare reply words as they arrive
  initial begin
    forever begin
      wait (obs_q.size() != 0);
      chk("R6 reply word", obs_q.pop_front(), exp_q.pop_front());
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] seed;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v);
      chk("R1 reset read", v, 32'd0);
    end
    chk("R1 count", {22'b0, xfer_cnt}, 32'd0);
    chk("R1 frame", {31'b0, frame_done}, 32'd0);

    // R2 host data readback
    wr(4'h0, 32'hA5A5_1234);
    rd(4'h0, v); chk("R2 readback", v, 32'hA5A5_1234);

    // R3 upper control bits dropped
    wr(4'h8, 32'hFFFF_FFFE);
    rd(4'h8, v); chk("R3 ctrl bits", v, 32'd0);
    @(negedge clk);
    rd(4'hC, v); chk("R7 no false toggle", v, 32'd0);

    // R8 fabric-owned and misaligned writes ignored
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h9, 32'h0000_0001);
    @(negedge clk);
    rd(4'h4, v); chk("R8 reply ro", v, 32'd0);
    rd(4'hC, v); chk("R8 fctrl ro", v, 32'd0);
    rd(4'h8, v); chk("R8 misaligned", v, 32'd0);

    // exchanges, both toggle directions
    exchange(32'h8000_0001);
    exchange(32'h0000_0000);
    exchange(32'hFFFF_FFFF);
    exchange(32'h1234_5678);

    // R7 idle rewrite and data-only write
    wr(4'h8, {31'b0, hc_model});
    wr(4'h0, 32'hDEAD_BEEF);
    @(negedge clk);
    rd(4'hC, v); chk("R7 fctrl held", v, {31'b0, fc_model});
    rd(4'h4, v); chk("R7 reply held", v, last_reply);
    chk("R7 count held", {22'b0, xfer_cnt}, cnt_model);

    // R8 after activity
    wr(4'h4, 32'h0BAD_0BAD);
    @(negedge clk);
    rd(4'h4, v); chk("R8 reply held", v, last_reply);

    // rest of the frame up to the wrap, then a few more
    seed = 32'h1357_9BDF;
    for (int i = 4; i < 1027; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      exchange(seed);
    end
    @(negedge clk);
    chk("R10 pulse gone", {31'b0, frame_done}, 32'd0);

    #1;
    wait (obs_q.size() == 0);
    #1;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule